// File: doc/BRIEF.md
# Minimum On/Off-Time Hysteretic Switch Controller

This block is the digital core of a step-down converter controller that runs on a single comparator bit. When the comparator reports that the output has sagged below its regulation threshold, the block opens a conduction cycle on the high-side switch. That switch stays on for at least a programmable number of clock cycles. Once the output has recovered, the high-side switch is held off for at least a programmable number of cycles. While the high-side switch is off, the low-side switch conducts as a synchronous rectifier. A zero-current input cuts the low-side switch off early, so the inductor current cannot reverse. This gives discontinuous, pulse-frequency operation at light load.

A programmable maximum on-time caps the high-side duty cycle. As load rises, the off periods shrink to their minimum and the switching period settles to a near-constant value. The block times the interval between successive high-side turn-ons. It raises a continuous-mode flag once that interval has stayed inside a programmed window for a set number of consecutive cycles. A global enable parks both switches off and clears every timer and the flag.

Top module: `hyst_sw_ctrl`

## Requirements
- R1: A high-side pulse begins exactly two cycles after the clock edge at which the controller is in an off-period cycle, has completed at least `min_off` off-period cycles (counting this one), and samples `below_thr` high. The cycle between is a dead cycle with both enables low.
- R2: A high-side pulse lasts at least `min_on` cycles. Once that count is reached (and the cap of R3 is not), it ends at the first clock edge that samples `below_thr` low. `min_on` of 0 acts as 1.
- R3: A high-side pulse never lasts more than `max_on` cycles. It is forced to end when that count is reached, even if `below_thr` is still high. `max_on` takes precedence over `min_on`.
- R4: No high-side pulse starts during the dead cycle after a pulse, nor during an off period that has not completed `min_off` cycles.
- R5: From the second cycle after a high-side pulse ends until the dead cycle before the next pulse, `ls_en` is high. The exception is set out in R7.
- R6: `hs_en` and `ls_en` are never high in the same cycle. Each enable only rises in a cycle that follows one in which the other enable was low.
- R7: A `zero_cur` high sampled while `ls_en` is high forces `ls_en` low from the next cycle until the next high-side pulse begins.
- R8: The measured period is the number of cycles between two consecutive `hs_en` rises. Consider each new `hs_en` rise whose measured period lies within `per_lo`..`per_hi` (inclusive) and is not the first rise after enable. `ccm_mode` is high in the cycle of that rise, and after it, if and only if at least `LOCK_CNT` consecutive measured periods were in the window. The flag changes only together with an `hs_en` rise or under R9.
- R9: When the count of cycles since the last `hs_en` rise exceeds `per_hi`, the consecutive count is cleared and `ccm_mode` goes low in that cycle.
- R10: While `en` is low, `hs_en`, `ls_en` and `ccm_mode` are low in the cycle after. When `en` rises, the controller starts with a dead cycle and then a full `min_off` off period. The first period measured after enable does not count toward R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable; low parks both switches and clears timers |
| below_thr | input | 1 | Comparator: output below regulation threshold |
| zero_cur | input | 1 | Inductor current reached zero during the off period |
| min_on | input | TW | Minimum high-side on-time in cycles |
| min_off | input | TW | Minimum off period in cycles (rectifier phase) |
| max_on | input | TW | Maximum high-side on-time in cycles (duty cap) |
| per_lo | input | PW | Lower bound of the continuous-mode period window |
| per_hi | input | PW | Upper bound of the continuous-mode period window |
| hs_en | output | 1 | High-side switch gate enable |
| ls_en | output | 1 | Low-side switch gate enable |
| ccm_mode | output | 1 | High: continuous conduction; low: pulse-frequency operation |

## Verification
A wrong phase state shows up at the ports within one cycle. Examples are a skipped dead cycle, a pulse that starts early, or a low-side enable asserted during a dead cycle. Each appears as an enable that is high or low against the expected cycle-exact pattern. A wrong on- or off-timer value moves the next edge of `hs_en` by the size of the error. The bench detects this at the first pulse that depends on it. Corruption in the period monitor can stay hidden until the next `hs_en` rise, or until the elapsed count crosses `per_hi`. That is at most one switching period, after which `ccm_mode` disagrees with the streak the bench keeps.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_DT_HL = 3'd1,
      PH_OFF   = 3'd2,
      PH_DT_LH = 3'd3,
      PH_ON    = 3'd4
   } ph_t;
endpackage

// File: rtl/hsc_phase_fsm.sv
module hsc_phase_fsm
   import hsc_pkg::*;
#(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          below_thr,
   input  logic          zero_cur,
   input  logic [TW-1:0] min_on,
   input  logic [TW-1:0] min_off,
   input  logic [TW-1:0] max_on,
   output ph_t           ph,
   output logic          zc_lat
);
   localparam logic [TW-1:0] TMR_MAX = '1;

   ph_t           ph_nx;
   logic [TW-1:0] tmr;
   logic [TW:0]   elapsed;
   logic          on_min_met, on_cap_hit, off_min_met;

   // elapsed counts the current cycle of the phase, starting at 1
   assign elapsed     = {1'b0, tmr} + (TW+1)'(1);
   assign on_min_met  = elapsed >= {1'b0, min_on};
   assign on_cap_hit  = elapsed >= {1'b0, max_on};
   assign off_min_met = elapsed >= {1'b0, min_off};

   always_comb begin
      ph_nx = ph;
      unique case (ph)
         PH_IDLE:  ph_nx = PH_DT_HL;
         PH_DT_HL: ph_nx = PH_OFF;
         PH_OFF:   if (off_min_met && below_thr) ph_nx = PH_DT_LH;
         PH_DT_LH: ph_nx = PH_ON;
         PH_ON:    if (on_cap_hit || (on_min_met && !below_thr)) ph_nx = PH_DT_HL;
         default:  ph_nx = PH_IDLE;
      endcase
      if (!en) ph_nx = PH_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         tmr    <= '0;
         zc_lat <= 1'b0;
      end else begin
         ph <= ph_nx;
         if (!en || ph_nx != ph) tmr <= '0;
         else if (tmr != TMR_MAX) tmr <= tmr + TW'(1);
         if (ph_nx != PH_OFF) zc_lat <= 1'b0;
         else if (ph == PH_OFF && zero_cur) zc_lat <= 1'b1;
      end
   end
endmodule

// File: rtl/hsc_period_mon.sv
module hsc_period_mon #(
   parameter int unsigned PW       = 10,
   parameter int unsigned LOCK_CNT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          start,
   input  logic [PW-1:0] per_lo,
   input  logic [PW-1:0] per_hi,
   output logic          ccm
);
   localparam logic [PW-1:0] PER_MAX = '1;

   logic [PW-1:0] per_cnt;
   logic          per_vld, in_win, over;

   assign in_win = per_vld && per_cnt >= per_lo && per_cnt <= per_hi;
   assign over   = per_vld && per_cnt > per_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_cnt <= '0;
         per_vld <= 1'b0;
      end else if (!en) begin
         per_cnt <= '0;
         per_vld <= 1'b0;
      end else if (start) begin
         per_cnt <= PW'(1);
         per_vld <= 1'b1;
      end else if (per_cnt != PER_MAX) begin
         per_cnt <= per_cnt + PW'(1);
      end
   end

   generate
      if (LOCK_CNT == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ccm <= 1'b0;
            else if (!en)   ccm <= 1'b0;
            else if (start) ccm <= in_win;
            else if (over)  ccm <= 1'b0;
         end
      end else begin : g_streak
         localparam int unsigned SW = $clog2(LOCK_CNT + 1);
         localparam logic [SW-1:0] LOCK_V = SW'(LOCK_CNT);
         logic [SW-1:0] streak, streak_nx;

         always_comb begin
            streak_nx = streak;
            if (!en) streak_nx = '0;
            else if (start) begin
               if (!in_win) streak_nx = '0;
               else if (streak != LOCK_V) streak_nx = streak + SW'(1);
            end else if (over) streak_nx = '0;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               streak <= '0;
               ccm    <= 1'b0;
            end else begin
               streak <= streak_nx;
               ccm    <= streak_nx >= LOCK_V;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/hyst_sw_ctrl.sv
module hyst_sw_ctrl
   import hsc_pkg::*;
#(
   parameter int unsigned TW       = 8,
   parameter int unsigned PW       = 10,
   parameter int unsigned LOCK_CNT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          below_thr,
   input  logic          zero_cur,
   input  logic [TW-1:0] min_on,
   input  logic [TW-1:0] min_off,
   input  logic [TW-1:0] max_on,
   input  logic [PW-1:0] per_lo,
   input  logic [PW-1:0] per_hi,
   output logic          hs_en,
   output logic          ls_en,
   output logic          ccm_mode
);
   initial begin
      assert (TW >= 2) else $error("TW must be at least 2");
      assert (PW >= 2) else $error("PW must be at least 2");
      assert (LOCK_CNT >= 1) else $error("LOCK_CNT must be at least 1");
   end

   ph_t  ph;
   logic zc_lat;

   hsc_phase_fsm #(.TW(TW)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .below_thr (below_thr),
      .zero_cur  (zero_cur),
      .min_on    (min_on),
      .min_off   (min_off),
      .max_on    (max_on),
      .ph        (ph),
      .zc_lat    (zc_lat)
   );

   hsc_period_mon #(.PW(PW), .LOCK_CNT(LOCK_CNT)) u_mon (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .start  (ph == PH_DT_LH && en),
      .per_lo (per_lo),
      .per_hi (per_hi),
      .ccm    (ccm_mode)
   );

   assign hs_en = (ph == PH_ON);
   assign ls_en = (ph == PH_OFF) && !zc_lat;
endmodule

// File: rtl/hsc_chk.sv
module hsc_chk #(
   parameter int unsigned TW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en,
   input logic          zero_cur,
   input logic          hs_en,
   input logic          ls_en,
   input logic          ccm_mode,
   input logic [TW-1:0] max_on
);
   logic [TW:0] hs_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    hs_run <= '0;
      else if (!hs_en)               hs_run <= '0;
      else if (hs_run != '1)         hs_run <= hs_run + (TW+1)'(1);
   end

   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en && ls_en));

   p_dead_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> !$past(ls_en));

   p_dead_ls_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_en) |-> !$past(hs_en));

   p_max_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_en && max_on != '0) |-> (hs_run < {1'b0, max_on}));

   p_zero_cur_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_cur && ls_en) |=> !ls_en);

   p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!hs_en && !ls_en && !ccm_mode));

   p_flag_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ccm_mode) |-> $rose(hs_en));
endmodule

bind hyst_sw_ctrl hsc_chk #(.TW(TW)) u_hsc_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .zero_cur (zero_cur),
   .hs_en    (hs_en),
   .ls_en    (ls_en),
   .ccm_mode (ccm_mode),
   .max_on   (max_on)
);

// File: tb/hyst_sw_ctrl_tb_top.sv
`timescale 1ns/1ps
module hyst_sw_ctrl_tb_top;
   localparam int TW   = 8;
   localparam int PW   = 10;
   localparam int LOCK = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          below_thr = 1'b0;
   logic          zero_cur = 1'b0;
   logic [TW-1:0] min_on = '0, min_off = '0, max_on = '0;
   logic [PW-1:0] per_lo = '0, per_hi = '0;
   logic          hs_en, ls_en, ccm_mode;

   always #2.5 clk = ~clk;

   hyst_sw_ctrl #(.TW(TW), .PW(PW), .LOCK_CNT(LOCK)) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .below_thr(below_thr), .zero_cur(zero_cur),
      .min_on(min_on), .min_off(min_off), .max_on(max_on),
      .per_lo(per_lo), .per_hi(per_hi),
      .hs_en(hs_en), .ls_en(ls_en), .ccm_mode(ccm_mode)
   );

   int  n_chk = 0, n_fail = 0;
   bit  finished = 0;
   // reference model state
   int  cfg_on, cfg_off, cfg_max, cfg_lo, cfg_hi;
   int  g = 0, cd = 0, run = 0, el = 0, streak = 0;
   bit  vld = 0, exp_fall = 0, zc_seen = 0, en_seen = 0, p_hs = 0, p_ls = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic bit in_window(int p);
      return p >= cfg_lo && p <= cfg_hi;
   endfunction

   task automatic sample_step();
      bit hs, ls, cc, exp_rise, exp_dtlh, exp_ls, exp_cc, rise;
      hs = hs_en; ls = ls_en; cc = ccm_mode;
      if (!en_seen) begin
         chk(!hs, "R10 high side off while disabled", hs, 0);
         chk(!ls, "R10 low side off while disabled", ls, 0);
         chk(!cc, "R10 mode flag clear while disabled", cc, 0);
         g = 0; cd = 0; run = 0; exp_fall = 0; zc_seen = 0;
         vld = 0; streak = 0; el = 0;
      end else begin
         exp_rise = (cd == 1);
         exp_dtlh = (cd == 2);
         if (cd > 0) cd--;
         rise = hs && !p_hs;
         chk(!(hs && ls), "R6 both enables high", int'(hs) + int'(ls), 1);
         if (rise)       chk(!p_ls, "R6 dead cycle before high side", p_ls, 0);
         if (ls && !p_ls) chk(!p_hs, "R6 dead cycle before low side", p_hs, 0);
         if (!p_hs) begin
            if (exp_rise) chk(hs, "R1 pulse start two cycles after below", hs, 1);
            else          chk(!hs, "R4 no start before minimum off period", hs, 0);
         end else begin
            if (exp_fall) chk(!hs, (run >= cfg_max) ? "R3 pulse capped at max_on"
                                                    : "R2 pulse ends after below drops", hs, 0);
            else          chk(hs, "R2 pulse held for minimum on-time", hs, 1);
         end
         if (hs) begin run = p_hs ? run + 1 : 1; g = 0; zc_seen = 0; end
         else begin run = 0; g++; end
         exp_ls = !hs && g >= 2 && !exp_dtlh && !zc_seen;
         chk(ls == exp_ls, zc_seen ? "R7 low side cut after zero current"
                                   : "R5 low side conducts in off period", ls, exp_ls);
         el++;
         if (rise) begin
            if (vld && in_window(el)) streak = (streak < LOCK) ? streak + 1 : LOCK;
            else streak = 0;
            vld = 1; el = 0;
         end else if (vld && el > cfg_hi) begin
            streak = 0;
         end
         exp_cc = streak >= LOCK;
         chk(cc == exp_cc, (vld && !rise && el > cfg_hi) ? "R9 flag dropped on long period"
                                                        : "R8 continuous-mode flag", cc, exp_cc);
      end
      p_hs = hs; p_ls = ls;
   endtask

   task automatic drive_step(input int pb, input int pz);
      bit b, z;
      b = ($urandom % 256) < pb;
      z = ($urandom % 256) < pz;
      below_thr = b;
      zero_cur  = z;
      exp_fall  = 0;
      if (en) begin
         if (p_hs) exp_fall = (run >= cfg_max) || (run >= cfg_on && !b);
         else if (g >= 2 && cd == 0) begin
            if (z) zc_seen = 1;
            if (b && (g - 1) >= cfg_off) cd = 2;
         end
      end
      en_seen = en;
   endtask

   task automatic run_phase(input int on_, off_, mx, lo_, hi_, pb, pz, n);
      repeat (3) begin
         @(negedge clk); sample_step(); en = 1'b0; drive_step(0, 0);
      end
      cfg_on = on_; cfg_off = off_; cfg_max = mx; cfg_lo = lo_; cfg_hi = hi_;
      min_on = TW'(on_); min_off = TW'(off_); max_on = TW'(mx);
      per_lo = PW'(lo_); per_hi = PW'(hi_);
      @(negedge clk); sample_step(); en = 1'b1; drive_step(pb, pz);
      repeat (n) begin
         @(negedge clk); sample_step(); drive_step(pb, pz);
      end
   endtask

   initial begin
      void'($urandom(32'h1ce5));
      repeat (4) @(negedge clk);
      chk(!hs_en && !ls_en && !ccm_mode, "R10 reset state", int'(hs_en) + int'(ls_en) + int'(ccm_mode), 0);
      rst_n = 1'b1;
      repeat (4) begin @(negedge clk); sample_step(); drive_step(128, 64); end
      // heavy load: capped pulses, minimum off, period 6+1+2+1 = 10 inside 9..11
      run_phase(3, 2, 6, 9, 11, 256, 0, 200);
      // same load, window excludes 10: flag must stay low
      run_phase(3, 2, 6, 11, 14, 256, 0, 200);
      // max_on below min_on: cap wins
      run_phase(5, 1, 3, 5, 8, 256, 0, 150);
      // zero minimum times
      run_phase(0, 0, 4, 3, 9, 128, 0, 400);
      // light load with zero-current cuts
      run_phase(2, 3, 20, 8, 16, 8, 40, 1500);
      // frequent zero-current pulses under moderate load
      run_phase(2, 2, 10, 6, 20, 160, 128, 800);
      // LOCK-1 in-window periods then a long one, repeated by random load
      run_phase(1, 1, 12, 5, 9, 200, 20, 1500);
      for (int k = 0; k < 12; k++) begin
         int lo_r;
         lo_r = 4 + int'($urandom % 17);
         run_phase(int'($urandom % 7), int'($urandom % 7), 1 + int'($urandom % 12),
                   lo_r, lo_r + int'($urandom % 11), int'($urandom % 257),
                   int'($urandom % 81), 1200);
      end
      // disable in the middle of heavy operation, then restart
      run_phase(2, 4, 5, 8, 14, 256, 0, 37);
      run_phase(2, 4, 5, 8, 14, 256, 0, 100);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule